// File: doc/BRIEF.md
# Multi-Master Bus Clock Synchronizer

This block generates the serial clock for one master on a two-wire, open-drain bus. Other masters share the same clock wire and may run at different rates. The master either pulls the clock wire low or releases it. It reads back the resolved wire level through a synchronizer and times each of its phases from the bus edges it observes, not from its own drive changes. As a result, every master on the wire settles into one wired-AND clock. That clock's low phase is set by the slowest master, and its high phase ends when the fastest master pulls the wire low again.

Low and high phase lengths are given in system clock cycles on two configuration inputs. After its low count expires, the master releases the wire and then waits, with its high count held at zero, until the wire is actually seen high. This lets any other device stretch the clock. If the wire is seen low before the local high count expires, the master drops the high phase at once and joins the low phase. The observed rising and falling edges of the bus clock are also offered as single-cycle strobes for a data shifter.

Top module: `wand_clk_sync`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_drive_low`, `bus_rise_stb` and `bus_fall_stb` are all 0.
- R2: With a single master on the wire, the bus clock low phase measured between a fall strobe and the next rise strobe is `low_count`+2 cycles. The high phase measured from a rise strobe to the next fall strobe is `high_count`+3 cycles.
- R3: One cycle after `enable` is sampled low, `bus_drive_low` is 0, and it stays 0 while `enable` stays low.
- R4: When a new level on `bus_clk_in` is first captured at clock edge n, the matching strobe is 1 for exactly the single cycle after edge n+1. A falling level gives `bus_fall_stb` and a rising level gives `bus_rise_stb`. Strobes follow the bus even while `enable` is low.
- R5: With two such masters on one wire, the resolved low phase is the larger of their low counts plus 2 cycles.
- R6: With two such masters on one wire, the resolved high phase is the smaller of their high counts plus 3 cycles.
- R7: After its low count expires, the master keeps the wire released for as long as the wire is held low by another device. The following high phase still lasts `high_count`+3 cycles, timed from the observed rise.
- R8: If the wire is seen low during the local high phase and `low_count` is at least 2, the master drives low in the next cycle.
- R9: A count of 0 on `low_count` or `high_count` behaves exactly like a count of 1.
- R10: When `enable` rises, the master drives the wire low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Clock generation enable |
| low_count | input | CNT_W (16) | Low phase length in system cycles |
| high_count | input | CNT_W (16) | High phase length in system cycles |
| bus_clk_in | input | 1 | Raw resolved bus clock level |
| bus_drive_low | output | 1 | Open-drain enable: 1 pulls the wire low |
| bus_rise_stb | output | 1 | One-cycle strobe on an observed rising edge |
| bus_fall_stb | output | 1 | One-cycle strobe on an observed falling edge |

## Verification
The bench places a second instance on the same wired-AND wire and checks phase lengths against max/min expectations over random count pairs. A design that timed its high phase from its own release, or failed to restart on a foreign falling edge, would show the local high length instead of the minimum. The one-sample skew between the master that causes an edge and the one that observes it is covered by equal low counts, including the count of 1 and count-0 cases, where an off-by-one makes the low phase one cycle long. An external hold of the wire low checks that a stretched clock neither causes the master to drive again nor shortens the next high phase.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } phase_e;
endpackage

// File: rtl/wcs_sync.sv
module wcs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wcs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wcs_edge.sv
module wcs_edge #(
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise_stb,
   output logic fall_stb
);
   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= RST_VAL;
      else        lvl_d <= lvl;
   end

   assign rise_stb = lvl & ~lvl_d;
   assign fall_stb = ~lvl & lvl_d;

   // R4
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> !rise_stb);
   // R4
   fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |=> !fall_stb);
endmodule

// File: rtl/wcs_phase.sv
module wcs_phase
   import wcs_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] low_count,
   input  logic [CNT_W-1:0] high_count,
   input  logic             bus_lvl,
   output logic             drive_low
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("wcs_phase: CNT_W must be at least 2");
      end
   endgenerate

   phase_e           state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lo_lim, hi_lim;
   logic [CNT_W:0]   cnt_nxt;
   logic             lo_done, hi_done;

   always_comb begin
      lo_lim  = (low_count  == '0) ? ONE : low_count;
      hi_lim  = (high_count == '0) ? ONE : high_count;
      cnt_nxt = {1'b0, cnt} + 1'b1;
      lo_done = cnt_nxt >= {1'b0, lo_lim};
      hi_done = cnt_nxt >= {1'b0, hi_lim};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PH_IDLE;
         cnt   <= '0;
      end else if (!enable) begin
         state <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            PH_IDLE: begin
               state <= PH_LOW;
               cnt   <= '0;
            end
            PH_LOW: begin
               if (bus_lvl) cnt <= '0;
               else if (lo_done) begin
                  state <= PH_WAIT;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_WAIT: begin
               cnt <= '0;
               if (bus_lvl) state <= PH_HIGH;
            end
            default: begin
               if (!bus_lvl) begin
                  if (lo_lim == ONE) begin
                     state <= PH_WAIT;
                     cnt   <= '0;
                  end else begin
                     state <= PH_LOW;
                     cnt   <= ONE;
                  end
               end else if (hi_done) begin
                  state <= PH_LOW;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
         endcase
      end
   end

   assign drive_low = (state == PH_LOW);

   // R3
   off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !drive_low);
   // R10
   start_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && state == PH_IDLE) |=> drive_low);
   // R8
   abandon_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && state == PH_HIGH && !bus_lvl && lo_lim != ONE) |=> drive_low);
   // R7
   stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && state == PH_WAIT && !bus_lvl) |=> !drive_low);
   // R5
   low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_LOW && $stable(low_count)) |-> (cnt < lo_lim));
   // R6
   high_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_HIGH && $stable(high_count)) |-> (cnt < hi_lim));
endmodule

// File: rtl/wand_clk_sync.sv
module wand_clk_sync #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] low_count,
   input  logic [CNT_W-1:0] high_count,
   input  logic             bus_clk_in,
   output logic             bus_drive_low,
   output logic             bus_rise_stb,
   output logic             bus_fall_stb
);
   logic bus_lvl;

   wcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_clk_in),
      .q     (bus_lvl)
   );

   wcs_edge #(.RST_VAL(1'b1)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (bus_lvl),
      .rise_stb (bus_rise_stb),
      .fall_stb (bus_fall_stb)
   );

   wcs_phase #(.CNT_W(CNT_W)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .low_count  (low_count),
      .high_count (high_count),
      .bus_lvl    (bus_lvl),
      .drive_low  (bus_drive_low)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!bus_rise_stb && !bus_fall_stb));
endmodule

// File: tb/wand_clk_sync_test.sv
module wand_clk_sync_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_a = 1'b0, en_b = 1'b0;
   logic [15:0] lo_a = 16'd4, hi_a = 16'd4, lo_b = 16'd4, hi_b = 16'd4;
   logic        ext_hold = 1'b1;
   logic        drv_a, drv_b, rise_a, fall_a, rise_b, fall_b;
   wire         bus = ~(drv_a | drv_b) & ext_hold;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   wand_clk_sync uut (
      .clk(clk), .rst_n(rst_n), .enable(en_a), .low_count(lo_a), .high_count(hi_a),
      .bus_clk_in(bus), .bus_drive_low(drv_a), .bus_rise_stb(rise_a), .bus_fall_stb(fall_a));

   wand_clk_sync peer (
      .clk(clk), .rst_n(rst_n), .enable(en_b), .low_count(lo_b), .high_count(hi_b),
      .bus_clk_in(bus), .bus_drive_low(drv_b), .bus_rise_stb(rise_b), .bus_fall_stb(fall_b));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int eff(input logic [15:0] v);
      return (v == 16'd0) ? 1 : int'(v);
   endfunction

   function automatic int exp_low(input bit two);
      int a = eff(lo_a);
      int b = eff(lo_b);
      return ((two && b > a) ? b : a) + 2;
   endfunction

   function automatic int exp_high(input bit two);
      int a = eff(hi_a);
      int b = eff(hi_b);
      return ((two && b < a) ? b : a) + 3;
   endfunction

   task automatic step_until(input bit want_rise, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(want_rise ? rise_a : fall_a) && n < 5000);
      if (n >= 5000) check("watchdog strobe", n, 0);
   endtask

   task automatic measure(output int lo, output int hi);
      int n;
      step_until(1'b0, n);
      step_until(1'b1, lo);
      step_until(1'b0, hi);
   endtask

   task automatic run_cfg(input string tag_lo, input string tag_hi);
      int lo, hi, d1, d2;
      measure(d1, d2);
      measure(d1, d2);
      measure(lo, hi);
      check(tag_lo, lo, exp_low(en_b));
      check(tag_hi, hi, exp_high(en_b));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int n;
      void'($urandom(32'h5eed_c1c));
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 drive", drv_a, 0);
      check("R1 rise", rise_a, 0);
      check("R1 fall", fall_a, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 fall after release", fall_a, 0);

      // R4: strobe latency and width, enable low
      ext_hold = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R4 fall early", fall_a, 0);
      @(negedge clk);
      check("R4 fall strobe", fall_a, 1);
      @(negedge clk);
      check("R4 fall width", fall_a, 0);
      ext_hold = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R4 rise strobe", rise_a, 1);
      @(negedge clk);
      check("R4 rise width", rise_a, 0);

      // R10: enable start
      en_a = 1'b1;
      @(negedge clk);
      check("R10 drive on enable", drv_a, 1);

      // R2: single master
      lo_a = 16'd5; hi_a = 16'd7;
      run_cfg("R2 low", "R2 high");
      lo_a = 16'd1; hi_a = 16'd1;
      run_cfg("R2 low min", "R2 high min");

      // R9: zero counts act as one
      lo_a = 16'd0; hi_a = 16'd0;
      run_cfg("R9 low zero", "R9 high zero");

      // R5 R6: two masters, directed equal and skewed
      en_b = 1'b1;
      lo_a = 16'd1; lo_b = 16'd1; hi_a = 16'd2; hi_b = 16'd2;
      run_cfg("R5 equal low1", "R6 equal high");
      lo_a = 16'd3; lo_b = 16'd9; hi_a = 16'd8; hi_b = 16'd2;
      run_cfg("R5 peer slow low", "R6 peer fast high");

      // R8: peer pulls low during uut high phase
      lo_a = 16'd4; lo_b = 16'd4; hi_a = 16'd20; hi_b = 16'd3;
      step_until(1'b0, n);
      step_until(1'b0, n);
      @(negedge clk);
      check("R8 abandon drive", drv_a, 1);

      // R5 R6: random pairs
      for (int i = 0; i < 8; i++) begin
         lo_a = 16'($urandom_range(0, 12));
         lo_b = 16'($urandom_range(0, 12));
         hi_a = 16'($urandom_range(0, 12));
         hi_b = 16'($urandom_range(0, 12));
         en_b = 1'($urandom_range(0, 1));
         run_cfg("R5 random low", "R6 random high");
      end

      // R7: external stretch with uut alone
      en_b = 1'b0;
      lo_a = 16'd4; hi_a = 16'd5;
      run_cfg("R7 base low", "R7 base high");
      step_until(1'b0, n);
      ext_hold = 1'b0;
      repeat (20) @(negedge clk);
      check("R7 released during stretch", drv_a, 0);
      ext_hold = 1'b1;
      step_until(1'b1, n);
      step_until(1'b0, n);
      check("R7 high after stretch", n, 8);

      // R3: disable releases the wire
      step_until(1'b0, n);
      @(negedge clk);
      en_a = 1'b0;
      @(negedge clk);
      check("R3 release", drv_a, 0);
      repeat (5) @(negedge clk);
      check("R3 stays released", drv_a, 0);

      finish_run();
   end
endmodule